// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a 256-byte data cache that sits between a processor load/store port and a slow line-oriented memory. It holds 16 sets of two 8-byte lines and serves one request at a time. A request names a 13-bit line number, which is a 16-bit byte address with its three offset bits dropped. Each request either reads the whole line or stores into it under an 8-bit byte mask. Each set keeps one bit that names its least recently used way, and each line keeps one valid bit and one dirty bit.

A hit is answered one cycle after the request is accepted. On a miss, the cache picks a victim. If the victim holds modified data, that line is first written back to memory, and the cache then asks memory for the missing line. When the refill arrives, the store bytes of a store miss are laid over it. The refilled line is installed and the processor receives its response. The request port is not ready while a miss is in progress.

Top module: `wb_dcache2w`

## Requirements
- R1: After a synchronous active-low reset, every line is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_req_valid` are 0.
- R2: A request hits when a valid way of set `cpu_req_line[3:0]` holds tag `cpu_req_line[12:4]`. A hit raises `cpu_rsp_valid` in the cycle after acceptance and makes no memory request.
- R3: A miss issues a read for the requested line number and keeps `cpu_req_ready` low until the refill arrives. The response then carries the refilled line.
- R4: On a miss into a set that still has an invalid way, the new line goes into that invalid way, and the valid line in the set stays resident.
- R5: Every hit or refill makes the set's replacement bit name the other way. When both ways are valid, a miss evicts the way that bit names.
- R6: A store hit replaces byte lane i (bits 8i+7..8i) with the store data wherever `cpu_req_be[i]` is 1, marks the line dirty, and returns the updated line.
- R7: A store miss lays the enabled store bytes over the refilled line, installs the result as dirty, and returns it.
- R8: Evicting a dirty line first writes that line, at its own line number and with its current contents, to memory. Only after that write is accepted is the refill read issued.
- R9: A line refilled by a load is clean, so a later eviction of that line writes nothing to memory.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the memory request and its write flag, line number and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_line | input | 13 | Line number: tag [12:4], set [3:0] |
| cpu_req_be | input | 8 | Store byte enable, one bit per byte lane |
| cpu_req_wdata | input | 64 | Store data, aligned to byte lanes |
| cpu_rsp_valid | output | 1 | Response valid for one cycle |
| cpu_rsp_rdata | output | 64 | Line contents after the access |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_line | output | 13 | Line number for the memory request |
| mem_req_wdata | output | 64 | Write-back data |
| mem_rsp_valid | input | 1 | Refill data present |
| mem_rsp_rdata | input | 64 | Refill line |

## Verification
The bench drives one set through a sequence in which its LRU bit is set to each way in turn, so an inverted or stale LRU bit evicts the line it just used. A design with that fault reports a miss, or a write it did not expect, on the next access. Two dirty evictions check that the write comes before the read and that it carries the stored bytes. A design that drops the write-back, or reads first, loses the data the test later reads back. A store miss with a sparse byte mask checks the merge over the refill. A line that was dirty, evicted and then reloaded by a load is evicted again to show its dirty bit was cleared. A stalled memory handshake checks that a design does not abandon or change its request while memory is not ready.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-way data cache.
package dc_pkg;
    // Controller phases: idle/lookup, write-back, refill request, refill wait.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FETCH = 2'd2,
        ST_WAIT  = 2'd3
    } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
`timescale 1ns/1ps
// Tag, valid, dirty and replacement state for a two-way cache.
// Lookup and victim choice are combinational on lk_set/lk_tag; all updates
// land on the same set at the clock edge. Assumes exactly two ways.
module dc_tag_store #(
    parameter int SET_W = 4,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_hit_way,
    output logic             vic_way,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic             fill_dirty,
    input  logic             mark_en,
    input  logic             mark_way,
    input  logic             touch_en,
    input  logic             touch_way
);
    localparam int SETS = 1 << SET_W;
    localparam int WAYS = 2;

    logic [WAYS-1:0]  match;
    logic [WAYS-1:0]  way_valid;
    logic [WAYS-1:0]  way_dirty;
    logic [TAG_W-1:0] way_tag [WAYS];
    logic [SETS-1:0]  lru_q;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic [SETS-1:0]  valid_q;
            logic [SETS-1:0]  dirty_q;
            logic [TAG_W-1:0] tag_q [SETS];

            assign way_valid[w] = valid_q[lk_set];
            assign way_dirty[w] = dirty_q[lk_set];
            assign way_tag[w]   = tag_q[lk_set];
            assign match[w]     = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);

            // Valid and dirty bits: set by a fill, dirtied by a store hit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= '0;
                    dirty_q <= '0;
                end else if (fill_en && (fill_way == 1'(w))) begin
                    valid_q[lk_set] <= 1'b1;
                    dirty_q[lk_set] <= fill_dirty;
                end else if (mark_en && (mark_way == 1'(w))) begin
                    dirty_q[lk_set] <= 1'b1;
                end
            end

            // Tag written on fill only.
            always_ff @(posedge clk) begin
                if (fill_en && (fill_way == 1'(w))) begin
                    tag_q[lk_set] <= lk_tag;
                end
            end
        end
    endgenerate

    // Hit detection and victim selection (invalid way first, else LRU way).
    always_comb begin
        lk_hit     = |match;
        lk_hit_way = match[1];
        if (!way_valid[0]) begin
            vic_way = 1'b0;
        end else if (!way_valid[1]) begin
            vic_way = 1'b1;
        end else begin
            vic_way = lru_q[lk_set];
        end
        vic_dirty = way_valid[vic_way] && way_dirty[vic_way];
        vic_tag   = way_tag[vic_way];
    end

    // Replacement bit: after a touch, it names the way not touched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[lk_set] <= ~touch_way;
        end
    end
endmodule

// File: rtl/dc_data_store.sv
`timescale 1ns/1ps
// Line data for a two-way cache: one combinational read port and one
// write port sharing the set index. Contents are not reset; the valid bits
// in the tag store guard every use.
module dc_data_store #(
    parameter int SET_W  = 4,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic [SET_W-1:0]  set_idx,
    input  logic              rd_way,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int SETS = 1 << SET_W;
    localparam int WAYS = 2;

    logic [LINE_W-1:0] way_line [WAYS];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic [LINE_W-1:0] mem_q [SETS];

            assign way_line[w] = mem_q[set_idx];

            // Line write for this way.
            always_ff @(posedge clk) begin
                if (wr_en && (wr_way == 1'(w))) begin
                    mem_q[set_idx] <= wr_line;
                end
            end
        end
    endgenerate

    assign rd_line = way_line[rd_way];
endmodule

// File: rtl/dc_byte_merge.sv
`timescale 1ns/1ps
// Byte-lane merge: each lane whose enable is set takes the update byte,
// every other lane keeps the base byte. Purely combinational.
module dc_byte_merge #(
    parameter int LINE_BYTES = 8
) (
    input  logic [8*LINE_BYTES-1:0] base,
    input  logic [8*LINE_BYTES-1:0] upd,
    input  logic [LINE_BYTES-1:0]   be,
    output logic [8*LINE_BYTES-1:0] merged
);
    generate
        for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
            assign merged[8*b +: 8] = be[b] ? upd[8*b +: 8] : base[8*b +: 8];
        end
    endgenerate
endmodule

// File: rtl/wb_dcache2w.sv
`timescale 1ns/1ps
// Two-way set-associative write-back data cache, one request at a time.
// Lookup happens combinationally in the idle cycle that accepts a request,
// so a hit answers in the next cycle. A miss writes back a dirty victim,
// then requests and waits for the refill, merges store bytes into it and
// answers. Memory handshakes are valid/ready; refill data arrives later
// on mem_rsp_valid. Assumes exactly one outstanding memory read.
module wb_dcache2w
    import dc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 8,
    parameter int NUM_SETS   = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cpu_req_valid,
    output logic                                   cpu_req_ready,
    input  logic                                   cpu_req_we,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   cpu_req_line,
    input  logic [LINE_BYTES-1:0]                  cpu_req_be,
    input  logic [8*LINE_BYTES-1:0]                cpu_req_wdata,
    output logic                                   cpu_rsp_valid,
    output logic [8*LINE_BYTES-1:0]                cpu_rsp_rdata,
    output logic                                   mem_req_valid,
    input  logic                                   mem_req_ready,
    output logic                                   mem_req_we,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   mem_req_line,
    output logic [8*LINE_BYTES-1:0]                mem_req_wdata,
    input  logic                                   mem_rsp_valid,
    input  logic [8*LINE_BYTES-1:0]                mem_rsp_rdata
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int TAG_W  = LA_W - SET_W;
    localparam int LINE_W = 8 * LINE_BYTES;

    dc_state_e         state_q, state_d;
    logic              req_we_q;
    logic [LA_W-1:0]   req_line_q;
    logic [LINE_BYTES-1:0] req_be_q;
    logic [LINE_W-1:0] req_wdata_q;
    logic              vic_way_q;
    logic [TAG_W-1:0]  vic_tag_q;
    logic [LINE_W-1:0] wb_line_q;
    logic              rsp_valid_q;
    logic [LINE_W-1:0] rsp_line_q;

    logic [LA_W-1:0]   lk_line;
    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit, lk_hit_way;
    logic              vic_way, vic_dirty;
    logic [TAG_W-1:0]  vic_tag;
    logic              rd_way;
    logic [LINE_W-1:0] rd_line;
    logic              accept, hit_acc, miss_acc, fill_ev;
    logic [LINE_W-1:0] mrg_base, mrg_upd, merged;
    logic [LINE_BYTES-1:0] mrg_be;
    logic              wr_en, wr_way;

    // Lookup address: live request while idle, latched request otherwise.
    always_comb begin
        lk_line  = (state_q == ST_IDLE) ? cpu_req_line : req_line_q;
        lk_set   = lk_line[SET_W-1:0];
        lk_tag   = lk_line[LA_W-1 -: TAG_W];
        accept   = cpu_req_valid && (state_q == ST_IDLE);
        hit_acc  = accept && lk_hit;
        miss_acc = accept && !lk_hit;
        fill_ev  = (state_q == ST_WAIT) && mem_rsp_valid;
        rd_way   = lk_hit ? lk_hit_way : vic_way;
    end

    // Merge inputs: store over the hit line, or pending store over refill.
    always_comb begin
        if (state_q == ST_WAIT) begin
            mrg_base = mem_rsp_rdata;
            mrg_upd  = req_wdata_q;
            mrg_be   = req_we_q ? req_be_q : '0;
        end else begin
            mrg_base = rd_line;
            mrg_upd  = cpu_req_wdata;
            mrg_be   = cpu_req_we ? cpu_req_be : '0;
        end
        wr_en  = (hit_acc && cpu_req_we) || fill_ev;
        wr_way = fill_ev ? vic_way_q : lk_hit_way;
    end

    dc_tag_store #(
        .SET_W (SET_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_set     (lk_set),
        .lk_tag     (lk_tag),
        .lk_hit     (lk_hit),
        .lk_hit_way (lk_hit_way),
        .vic_way    (vic_way),
        .vic_dirty  (vic_dirty),
        .vic_tag    (vic_tag),
        .fill_en    (fill_ev),
        .fill_way   (vic_way_q),
        .fill_dirty (req_we_q),
        .mark_en    (hit_acc && cpu_req_we),
        .mark_way   (lk_hit_way),
        .touch_en   (hit_acc || fill_ev),
        .touch_way  (wr_way)
    );

    dc_data_store #(
        .SET_W  (SET_W),
        .LINE_W (LINE_W)
    ) u_data (
        .clk     (clk),
        .set_idx (lk_set),
        .rd_way  (rd_way),
        .rd_line (rd_line),
        .wr_en   (wr_en),
        .wr_way  (wr_way),
        .wr_line (merged)
    );

    dc_byte_merge #(
        .LINE_BYTES (LINE_BYTES)
    ) u_merge (
        .base   (mrg_base),
        .upd    (mrg_upd),
        .be     (mrg_be),
        .merged (merged)
    );

    // Next phase of the miss sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_acc) state_d = vic_dirty ? ST_EVICT : ST_FETCH;
            ST_EVICT: if (mem_req_ready) state_d = ST_FETCH;
            ST_FETCH: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Memory request: write-back of the victim, then read of the missing line.
    always_comb begin
        mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FETCH);
        mem_req_we    = (state_q == ST_EVICT);
        mem_req_line  = (state_q == ST_EVICT) ? {vic_tag_q, req_line_q[SET_W-1:0]}
                                              : req_line_q;
        mem_req_wdata = wb_line_q;
    end

    // Control state and response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            rsp_valid_q <= hit_acc || fill_ev;
        end
    end

    // Request, victim and response data capture.
    always_ff @(posedge clk) begin
        if (hit_acc || fill_ev) begin
            rsp_line_q <= merged;
        end
        if (miss_acc) begin
            req_we_q    <= cpu_req_we;
            req_line_q  <= cpu_req_line;
            req_be_q    <= cpu_req_be;
            req_wdata_q <= cpu_req_wdata;
            vic_way_q   <= vic_way;
            vic_tag_q   <= vic_tag;
            wb_line_q   <= rd_line;
        end
    end

    assign cpu_req_ready = (state_q == ST_IDLE);
    assign cpu_rsp_valid = rsp_valid_q;
    assign cpu_rsp_rdata = rsp_line_q;
endmodule

// File: rtl/dc_checker.sv
`timescale 1ns/1ps
// Protocol and sequencing properties of the cache, attached by bind.
// Observes ports plus the tag-store hit signal.
module dc_checker #(
    parameter int LA_W   = 13,
    parameter int LINE_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [LA_W-1:0]   mem_req_line,
    input logic [LINE_W-1:0] mem_req_wdata,
    input logic              lk_hit
);
    // R1: reset leaves the block idle with no strobes.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (cpu_req_ready && !cpu_rsp_valid && !mem_req_valid));

    // R2: an accepted hit answers next cycle.
    p_hit_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && lk_hit) |=> cpu_rsp_valid);

    // R3: an accepted miss goes to memory and blocks new requests.
    p_miss_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready && !lk_hit)
        |=> (mem_req_valid && !cpu_rsp_valid && !cpu_req_ready));

    // R8: an accepted write-back is followed by the refill read.
    p_read_after_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && mem_req_ready) |=> (mem_req_valid && !mem_req_we));

    // R10: a stalled memory request holds steady.
    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready)
        |=> (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_line)
             && $stable(mem_req_wdata)));
endmodule

bind wb_dcache2w dc_checker #(
    .LA_W   (LA_W),
    .LINE_W (LINE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_line  (mem_req_line),
    .mem_req_wdata (mem_req_wdata),
    .lk_hit        (lk_hit)
);

// File: tb/wb_dcache2w_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each response and queues it, the
// monitor compares responses as they appear; a memory model logs traffic.
module wb_dcache2w_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req_valid, cpu_req_ready, cpu_req_we;
    logic [12:0] cpu_req_line;
    logic [7:0]  cpu_req_be;
    logic [63:0] cpu_req_wdata;
    logic        cpu_rsp_valid;
    logic [63:0] cpu_rsp_rdata;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [12:0] mem_req_line;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int rsp_cnt = 0;

    logic [63:0] mem_img [int];
    logic [63:0] ref_img [int];
    logic [63:0] exp_q [$];
    string       exp_req_q [$];
    logic        log_we [$];
    logic [12:0] log_line [$];

    bit          rd_pend = 1'b0;
    int          rd_cnt  = 0;
    logic [12:0] rd_line_p;

    always #2.5 clk = ~clk;

    wb_dcache2w u_dut (.*);

    function automatic logic [63:0] init_line(input logic [12:0] ln);
        return {16'(ln ^ 13'h0ADE), 16'(ln * 3), 16'h5A5A, 3'b000, ln};
    endfunction

    function automatic logic [63:0] mem_line(input logic [12:0] ln);
        return mem_img.exists(int'(ln)) ? mem_img[int'(ln)] : init_line(ln);
    endfunction

    function automatic logic [63:0] ref_line(input logic [12:0] ln);
        return ref_img.exists(int'(ln)) ? ref_img[int'(ln)] : init_line(ln);
    endfunction

    function automatic logic [12:0] ln_of(input int tag, input int set);
        return {9'(tag), 4'(set)};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: handshakes seen at negedge complete at the next posedge.
    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rd_pend) begin
            if (rd_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem_line(rd_line_p);
                rd_pend = 1'b0;
            end else begin
                rd_cnt--;
            end
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            log_we.push_back(mem_req_we);
            log_line.push_back(mem_req_line);
            if (mem_req_we) begin
                mem_img[int'(mem_req_line)] = mem_req_wdata;
            end else begin
                rd_pend   = 1'b1;
                rd_cnt    = 4;
                rd_line_p = mem_req_line;
            end
        end
    end

    // Monitor: compare each response with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && cpu_rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R3", "unexpected response", cpu_rsp_rdata, 64'hx);
            end else begin
                check(exp_req_q.pop_front(), "response line", cpu_rsp_rdata, exp_q.pop_front());
            end
            rsp_cnt++;
        end
    end

    // Driver: kind 0 = hit, 1 = clean miss, 2 = dirty miss evicting vln.
    task automatic access(input bit we, input logic [12:0] ln, input logic [7:0] be,
                          input logic [63:0] wd, input int kind,
                          input logic [12:0] vln, input string req);
        logic [63:0] e;
        int          log0;
        int          tgt;
        e = ref_line(ln);
        if (we) begin
            for (int b = 0; b < 8; b++) if (be[b]) e[8*b +: 8] = wd[8*b +: 8];
        end
        ref_img[int'(ln)] = e;
        exp_q.push_back(e);
        exp_req_q.push_back(req);
        log0 = log_we.size();
        tgt  = rsp_cnt + 1;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_line  = ln;
        cpu_req_be    = be;
        cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        @(posedge clk);
        #1 cpu_req_valid = 1'b0;
        @(negedge clk);
        check(req, "response in cycle after accept", 64'(cpu_rsp_valid), 64'(kind == 0));
        wait (rsp_cnt >= tgt);
        if (kind == 0) begin
            check(req, "memory traffic on hit", 64'(log_we.size() - log0), 64'd0);
        end else begin
            check(req, "memory request count", 64'(log_we.size() - log0),
                  64'((kind == 2) ? 2 : 1));
            if (log_we.size() > log0) begin
                check(req, "refill is a read", 64'(log_we[log_we.size()-1]), 64'd0);
                check(req, "refill line", 64'(log_line[log_line.size()-1]), 64'(ln));
            end
            if (kind == 2 && log_we.size() >= log0 + 2) begin
                check("R8", "write-back first", 64'(log_we[log0]), 64'd1);
                check("R8", "write-back line", 64'(log_line[log0]), 64'(vln));
                check("R8", "write-back data", mem_line(vln), ref_line(vln));
            end
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n         = 1'b0;
        mem_req_ready = 1'b1;
        cpu_req_valid = 1'b0;
        cpu_req_we    = 1'b0;
        cpu_req_line  = '0;
        cpu_req_be    = '0;
        cpu_req_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", 64'(cpu_req_ready), 64'd1);
        check("R1", "no response after reset", 64'(cpu_rsp_valid), 64'd0);
        check("R1", "no memory request after reset", 64'(mem_req_valid), 64'd0);

        // Set 2: A=1, B=2, C=3, D=4, E=5.
        access(0, ln_of(1, 2), 8'h00, 64'h0, 1, 13'h0, "R3");   // fill way0, LRU->1
        access(0, ln_of(1, 2), 8'h00, 64'h0, 0, 13'h0, "R2");   // hit
        access(1, ln_of(1, 2), 8'h0F, 64'hDEAD_BEEF_CAFE_F00D, 0, 13'h0, "R6");
        access(0, ln_of(2, 2), 8'h00, 64'h0, 1, 13'h0, "R4");   // invalid way1, no WB
        access(0, ln_of(1, 2), 8'h00, 64'h0, 0, 13'h0, "R4");   // A still resident
        access(0, ln_of(3, 2), 8'h00, 64'h0, 1, 13'h0, "R5");   // evicts B (clean)
        access(0, ln_of(1, 2), 8'h00, 64'h0, 0, 13'h0, "R5");   // A survived
        access(0, ln_of(2, 2), 8'h00, 64'h0, 1, 13'h0, "R5");   // evicts C
        access(0, ln_of(2, 2), 8'h00, 64'h0, 0, 13'h0, "R5");   // LRU -> A
        access(0, ln_of(5, 2), 8'h00, 64'h0, 2, ln_of(1, 2), "R8"); // dirty A out
        access(0, ln_of(1, 2), 8'h00, 64'h0, 1, 13'h0, "R8");   // A back with stored bytes
        access(0, ln_of(3, 2), 8'h00, 64'h0, 1, 13'h0, "R9");   // evicts E
        access(0, ln_of(4, 2), 8'h00, 64'h0, 1, 13'h0, "R9");   // evicts clean A, no write

        // Set 5: store miss merge, then dirty eviction of it.
        access(1, ln_of(6, 5), 8'hA5, 64'h1122_3344_5566_7788, 1, 13'h0, "R7");
        access(0, ln_of(7, 5), 8'h00, 64'h0, 1, 13'h0, "R7");
        access(0, ln_of(8, 5), 8'h00, 64'h0, 2, ln_of(6, 5), "R7");
        access(0, ln_of(6, 5), 8'h00, 64'h0, 1, 13'h0, "R7");   // merged bytes persisted

        // Set 9: memory stalls the refill request.
        @(posedge clk);
        #1 mem_req_ready = 1'b0;
        fork
            access(0, ln_of(9, 9), 8'h00, 64'h0, 1, 13'h0, "R10");
            begin
                repeat (5) @(negedge clk);
                check("R10", "request held while stalled", 64'(mem_req_valid), 64'd1);
                check("R10", "line held while stalled", 64'(mem_req_line), 64'(ln_of(9, 9)));
                check("R10", "stalled request not ready-accepted", 64'(cpu_req_ready), 64'd0);
            end
            begin
                repeat (8) @(posedge clk);
                #1 mem_req_ready = 1'b1;
            end
        join
        access(0, ln_of(9, 9), 8'h00, 64'h0, 0, 13'h0, "R2");

        repeat (4) @(negedge clk);
        check("R3", "all responses consumed", 64'(exp_q.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule